// File: doc/BRIEF.md
# CCD Vertical Transfer Sequencer

This block drives the two vertical clock phases of an interline CCD image sensor. Each phase leaves the block as a 2-bit level selection for an external level-shifting driver, which turns the code into a low, mid or high rail voltage. The block runs two kinds of transfer. The first is a frame-start transfer. It places a long high-level pulse on phase 2 between three pedestal intervals, which moves photodiode charge into the vertical registers. The second is a per-line shift that moves one row, or two rows in 2x2 binning mode, toward the horizontal register. When a line shift finishes, the block raises a one-cycle start pulse for the horizontal readout logic.

All durations are counted in system clock cycles. Each one is a parameter. The defaults assume a 100 MHz clock, so 100 cycles equal 1 us. A line request that arrives while a transfer is running is remembered and served once the block becomes free. A frame request that arrives while the block is busy is dropped.

Top module: `ccd_vseq`

## Requirements
- R1: During and after reset the block rests with phase 1 at mid (01), phase 2 at low (00), `h_start` low and `busy` low.
- R2: Level codes are 00 = low, 01 = mid and 10 = high. The code 11 never appears on either phase output.
- R3: A frame request taken at rest starts a sequence on the following cycle, made of four stages:
  - phase 1 low and phase 2 mid for `T_PED1` cycles;
  - phase 1 low and phase 2 high for `T_HIGH` cycles;
  - phase 1 low and phase 2 mid for `T_PED2` cycles;
  - both phases mid for `T_PED3` cycles.
  After the last stage the block returns to rest and gives no `h_start`.
- R4: Phase 1 is never driven high. Phase 2 is high only while phase 1 is low.
- R5: A normal-mode line starts on the cycle after its request is taken, with these stages:
  - phase 1 low and phase 2 mid for `T_NB_PULSE` cycles;
  - phase 1 mid and phase 2 low for `T_NB_TAIL + T_NB_HDLY` cycles;
  - one cycle with `h_start` high;
  - a return to rest.
- R6: A binning-mode line runs two pulses. Each pulse is phase 1 low and phase 2 mid for `T_BIN_HI` cycles, followed by phase 1 mid and phase 2 low for `T_BIN_LO` cycles. The second low part is extended by `T_BIN_HDLY` cycles. One `h_start` cycle and a return to rest follow.
- R7: The mode input is sampled only on the cycle a line is taken. A change to the mode input during a line has no effect on that line.
- R8: A line request made while the block is busy is held, one deep. The block serves it after exactly one rest cycle that follows the end of the running transfer.
- R9: A frame request made while the block is busy is ignored. No frame sequence follows it.
- R10: If a frame request and a line request arrive together at rest, the frame runs first and the line is held under R8.
- R11: `busy` is high in every cycle that is not a rest cycle, including the `h_start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame-start transfer request, sampled each cycle |
| line_go | input | 1 | Line shift request, sampled each cycle |
| bin_mode | input | 1 | 1 selects 2x2 binning for the line being taken |
| v1_lvl | output | 2 | Phase 1 level code |
| v2_lvl | output | 2 | Phase 2 level code |
| h_start | output | 1 | One-cycle horizontal readout start |
| busy | output | 1 | A transfer is in progress |

## Verification
The hardest situations to reach are requests that land inside a running transfer: a line request held across a frame or another line, a frame request that must be dropped, and a mode change after a line has begun. The stimulus reaches them by injecting each request at a chosen cycle offset within a checked stage. It then follows the expected waveform cycle by cycle into the held line, which shows both when the held line starts and which mode it uses. Randomly chosen mode, hold and mode-flip combinations from a fixed seed are mixed with directed cases for simultaneous requests and dropped frames.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    typedef enum logic [3:0] {
        ST_REST,
        ST_FPED1,
        ST_FHIGH,
        ST_FPED2,
        ST_FPED3,
        ST_LPULSE,
        ST_LLOW,
        ST_LHDLY,
        ST_LHSTART
    } vstate_e;

    typedef struct packed {
        vstate_e st;
        logic    bin;
        logic    second;
    } seq_s;

endpackage

// File: rtl/vseq_timer.sv
module vseq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // Stage lengths depend on the loaded count being taken exactly (R3)
    assert_load_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/vseq_pend.sv
module vseq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic take,
    output logic pend
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (take)     pend_d = 1'b0;
        else if (req) pend_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !take) |=> pend_q);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !pend_q);
endmodule

// File: rtl/vseq_levels.sv
module vseq_levels
    import vseq_pkg::*;
(
    input  vstate_e    st,
    output logic [1:0] v1,
    output logic [1:0] v2
);
    lvl_e l1, l2;

    always_comb begin
        l1 = LVL_MID;
        l2 = LVL_LOW;
        case (st)
            ST_FPED1:  begin l1 = LVL_LOW; l2 = LVL_MID;  end
            ST_FHIGH:  begin l1 = LVL_LOW; l2 = LVL_HIGH; end
            ST_FPED2:  begin l1 = LVL_LOW; l2 = LVL_MID;  end
            ST_FPED3:  begin l1 = LVL_MID; l2 = LVL_MID;  end
            ST_LPULSE: begin l1 = LVL_LOW; l2 = LVL_MID;  end
            default:   begin l1 = LVL_MID; l2 = LVL_LOW;  end
        endcase
    end

    assign v1 = l1;
    assign v2 = l2;
endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
    import vseq_pkg::*;
#(
    parameter int T_PED1     = 4000,
    parameter int T_HIGH     = 1500,
    parameter int T_PED2     = 1500,
    parameter int T_PED3     = 4000,
    parameter int T_NB_PULSE = 150,
    parameter int T_NB_TAIL  = 50,
    parameter int T_NB_HDLY  = 150,
    parameter int T_BIN_HI   = 50,
    parameter int T_BIN_LO   = 50,
    parameter int T_BIN_HDLY = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_go,
    input  logic       line_go,
    input  logic       bin_mode,
    output logic [1:0] v1_lvl,
    output logic [1:0] v2_lvl,
    output logic       h_start,
    output logic       busy
);
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int TMAX = imax(imax(imax(T_PED1, T_PED3), imax(T_HIGH, T_PED2)),
                               imax(imax(T_NB_PULSE, T_NB_TAIL + T_NB_HDLY),
                                    imax(T_BIN_HI, T_BIN_LO + T_BIN_HDLY)));
    localparam int CW = $clog2(TMAX + 1);

    seq_s           seq_d, seq_q;
    logic           adv, take, pend, tmr_zero;
    logic [CW-1:0]  load_val;

    function automatic logic [CW-1:0] dur_m1(input vstate_e s, input logic b, input logic sec);
        int d;
        case (s)
            ST_FPED1:  d = T_PED1;
            ST_FHIGH:  d = T_HIGH;
            ST_FPED2:  d = T_PED2;
            ST_FPED3:  d = T_PED3;
            ST_LPULSE: d = b ? T_BIN_HI : T_NB_PULSE;
            ST_LLOW:   d = b ? (sec ? T_BIN_LO + T_BIN_HDLY : T_BIN_LO)
                             : T_NB_TAIL + T_NB_HDLY;
            default:   d = 1;
        endcase
        return CW'(d - 1);
    endfunction

    always_comb begin
        seq_d = seq_q;
        adv   = 1'b0;
        take  = 1'b0;
        case (seq_q.st)
            ST_REST: begin
                if (frame_go) begin
                    seq_d.st = ST_FPED1;
                    adv      = 1'b1;
                end else if (pend || line_go) begin
                    seq_d.st     = ST_LPULSE;
                    seq_d.bin    = bin_mode;
                    seq_d.second = 1'b0;
                    adv          = 1'b1;
                    take         = 1'b1;
                end
            end
            ST_FPED1:  if (tmr_zero) begin seq_d.st = ST_FHIGH; adv = 1'b1; end
            ST_FHIGH:  if (tmr_zero) begin seq_d.st = ST_FPED2; adv = 1'b1; end
            ST_FPED2:  if (tmr_zero) begin seq_d.st = ST_FPED3; adv = 1'b1; end
            ST_FPED3:  if (tmr_zero) begin seq_d.st = ST_REST;  adv = 1'b1; end
            ST_LPULSE: if (tmr_zero) begin seq_d.st = ST_LLOW;  adv = 1'b1; end
            ST_LLOW: begin
                if (tmr_zero) begin
                    adv = 1'b1;
                    if (seq_q.bin && !seq_q.second) begin
                        seq_d.st     = ST_LPULSE;
                        seq_d.second = 1'b1;
                    end else begin
                        seq_d.st = ST_LHSTART;
                    end
                end
            end
            ST_LHSTART: if (tmr_zero) begin seq_d.st = ST_REST; adv = 1'b1; end
            default: begin seq_d.st = ST_REST; adv = 1'b1; end
        endcase
        load_val = dur_m1(seq_d.st, seq_d.bin, seq_d.second);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st     <= ST_REST;
            seq_q.bin    <= 1'b0;
            seq_q.second <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    vseq_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (load_val),
        .zero     (tmr_zero)
    );

    vseq_pend u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (line_go),
        .take  (take),
        .pend  (pend)
    );

    vseq_levels u_levels (
        .st (seq_q.st),
        .v1 (v1_lvl),
        .v2 (v2_lvl)
    );

    assign h_start = (seq_q.st == ST_LHSTART);
    assign busy    = (seq_q.st != ST_REST);

    assert_no_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_lvl != 2'b11) && (v2_lvl != 2'b11));
    assert_v1_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        v1_lvl != 2'b10);
    assert_high_with_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v2_lvl == 2'b10) |-> (v1_lvl == 2'b00));
    assert_hstart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |=> !h_start);
    assert_hstart_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        h_start |-> busy);
    assert_frame_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_go && v2_lvl != 2'b10 && v1_lvl == 2'b01) |=> (v2_lvl != 2'b10));
endmodule

// File: tb/ccd_vseq_tb.sv
`timescale 1ns/1ps
module ccd_vseq_tb;
    localparam int P1 = 40, PH = 17, P2 = 15, P3 = 40;
    localparam int NBP = 15, NBT = 5, NBH = 15;
    localparam int BH = 5, BL = 5, BHD = 5;
    localparam logic [1:0] LO = 2'b00, MI = 2'b01, HI = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_go = 1'b0, line_go = 1'b0, bin_mode = 1'b0;
    logic [1:0] v1_lvl, v2_lvl;
    logic h_start, busy;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ccd_vseq #(
        .T_PED1(P1), .T_HIGH(PH), .T_PED2(P2), .T_PED3(P3),
        .T_NB_PULSE(NBP), .T_NB_TAIL(NBT), .T_NB_HDLY(NBH),
        .T_BIN_HI(BH), .T_BIN_LO(BL), .T_BIN_HDLY(BHD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .line_go(line_go),
        .bin_mode(bin_mode), .v1_lvl(v1_lvl), .v2_lvl(v2_lvl),
        .h_start(h_start), .busy(busy)
    );

    function automatic int low_len(input bit m, input bit last);
        if (!m) return NBT + NBH;
        return last ? BL + BHD : BL;
    endfunction

    // Checks n consecutive cycles at falling edges; il/ifr inject requests.
    task automatic seg(input logic [1:0] e1, input logic [1:0] e2, input int n,
                       input bit ehs, input bit ebz, input string tag,
                       input int il, input int ifr);
        bit bad = 0;
        logic [1:0] a1 = 0, a2 = 0;
        logic ah = 0, ab = 0;
        int at = 0;
        for (int i = 0; i < n; i++) begin
            line_go  = (i == il);
            frame_go = (i == ifr);
            if (!bad && (v1_lvl !== e1 || v2_lvl !== e2 || h_start !== ehs || busy !== ebz)) begin
                bad = 1; a1 = v1_lvl; a2 = v2_lvl; ah = h_start; ab = busy; at = i;
            end
            @(negedge clk);
        end
        line_go  = 0;
        frame_go = 0;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s cycle %0d: v1=%b v2=%b hs=%b busy=%b expected v1=%b v2=%b hs=%b busy=%b",
                     tag, at, a1, a2, ah, ab, e1, e2, ehs, ebz);
        end
    endtask

    task automatic start_line(input bit m);
        bin_mode = m;
        line_go  = 1;
        @(negedge clk);
        line_go  = 0;
    endtask

    task automatic start_frame(input bit with_line);
        frame_go = 1;
        line_go  = with_line;
        @(negedge clk);
        frame_go = 0;
        line_go  = 0;
    endtask

    task automatic run_frame(input bit req_line, input bit req_frame);
        seg(LO, MI, P1, 0, 1, "R3 ped1", req_line ? 3 : -1, req_frame ? 5 : -1);
        seg(LO, HI, PH, 0, 1, "R3 R4 high", -1, -1);
        seg(LO, MI, P2, 0, 1, "R3 ped2", -1, -1);
        seg(MI, MI, P3, 0, 1, "R3 ped3", -1, -1);
    endtask

    task automatic run_line(input bit m, input bit req_line, input bit flip, input bit req_frame);
        if (flip) bin_mode = ~bin_mode;
        if (m) begin
            seg(LO, MI, BH, 0, 1, "R6 R7 pulse1", req_line ? 2 : -1, req_frame ? 1 : -1);
            seg(MI, LO, low_len(1, 0), 0, 1, "R6 low1", -1, -1);
            seg(LO, MI, BH, 0, 1, "R6 pulse2", -1, -1);
            seg(MI, LO, low_len(1, 1), 0, 1, "R6 low2", -1, -1);
        end else begin
            seg(LO, MI, NBP, 0, 1, "R5 R7 pulse", req_line ? 2 : -1, req_frame ? 1 : -1);
            seg(MI, LO, low_len(0, 1), 0, 1, "R5 tail", -1, -1);
        end
        seg(MI, LO, 1, 1, 1, "R5 R11 hstart", -1, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        seg(MI, LO, 2, 0, 0, "R1 in reset", -1, -1);
        rst_n = 1;
        seg(MI, LO, 3, 0, 0, "R1 after reset", -1, -1);

        // R3 frame alone, then rest with no h_start
        start_frame(0);
        run_frame(0, 0);
        seg(MI, LO, 5, 0, 0, "R3 rest after frame", -1, -1);

        // R5 normal line
        start_line(0);
        run_line(0, 0, 0, 0);
        seg(MI, LO, 4, 0, 0, "R5 rest", -1, -1);

        // R6 binning line
        start_line(1);
        run_line(1, 0, 0, 0);
        seg(MI, LO, 4, 0, 0, "R6 rest", -1, -1);

        // R7 mode flip mid-line, R8 held line uses new mode
        start_line(0);
        run_line(0, 1, 1, 0);
        seg(MI, LO, 1, 0, 0, "R8 gap", -1, -1);
        run_line(1, 0, 0, 0);
        seg(MI, LO, 4, 0, 0, "R8 rest", -1, -1);

        // R9 frame request during a line is dropped
        start_line(1);
        run_line(1, 0, 0, 1);
        seg(MI, LO, 8, 0, 0, "R9 no frame", -1, -1);

        // R9 frame request during a frame is dropped; R8 line held across frame
        bin_mode = 0;
        start_frame(0);
        run_frame(1, 1);
        seg(MI, LO, 1, 0, 0, "R8 gap after frame", -1, -1);
        run_line(0, 0, 0, 0);
        seg(MI, LO, 4, 0, 0, "R9 rest", -1, -1);

        // R10 simultaneous requests at rest
        bin_mode = 1;
        start_frame(1);
        run_frame(0, 0);
        seg(MI, LO, 1, 0, 0, "R10 gap", -1, -1);
        run_line(1, 0, 0, 0);
        seg(MI, LO, 3, 0, 0, "R10 rest", -1, -1);

        // Random mix
        for (int k = 0; k < 24; k++) begin
            bit m   = 1'($urandom % 2);
            bit rq  = 1'($urandom % 2);
            bit fl  = 1'($urandom % 2);
            bit frm = 1'($urandom % 2);
            int gap = 1 + int'($urandom % 4);
            if (($urandom % 5) == 0) begin
                start_frame(0);
                run_frame(0, 0);
                seg(MI, LO, 1, 0, 0, "R3 rand rest", -1, -1);
            end
            start_line(m);
            run_line(m, rq, fl, frm);
            seg(MI, LO, 1, 0, 0, "R8 R11 rand gap", -1, -1);
            if (rq) begin
                run_line(m ^ fl, 0, 0, 0);
                seg(MI, LO, 1, 0, 0, "R8 rand rest", -1, -1);
            end
            seg(MI, LO, gap, 0, 0, "R9 R11 rand idle", -1, -1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule